// File: doc/BRIEF.md
# Time Base and Decrementer Counter Pair

This block holds a 64-bit up-counting time base and a 32-bit down-counting decrementer. Both advance on a shared single-cycle tick enable, which a clock divider outside the block produces. Software reaches the counters through one write port and one combinational read port, using a 2-bit select. Each half of the time base is a separate 32-bit word, and the decrementer is a single 32-bit word.

The decrementer raises an interrupt request in two cases. The first is when it counts down through zero, after which it wraps to all ones and keeps counting. The second is when software writes a value with bit 31 set while the current value has bit 31 clear. The request stays high until a one-cycle acknowledge clears it. A change on the tick-rate code input reloads the decrementer to all ones without raising the request.

A build-time parameter selects a real-time-clock variant. In that variant the lower time-base word is masked with 0x3FFFFF80 on both read and write, and the intended tick rate is 7,812,500 Hz.

Top module: `tbd_top`

## Requirements
- R1: After reset the lower word reads 0, the upper word reads 0, the decrementer reads 0xFFFFFFFF and `dec_irq` is 0.
- R2: Each cycle with `tick_en` high and no write adds one to the 64-bit time base, carrying from bit 31 into bit 32. Cycles without a tick leave it unchanged.
- R3: The select encoding is 0 = lower time-base word (bits 31:0), 1 = upper word (bits 63:32), 2 = decrementer. A write to one time-base word changes only that word.
- R4: Each tick with no write and no reload subtracts one from the decrementer. A tick at 0 loads 0xFFFFFFFF and raises `dec_irq` one cycle later.
- R5: A decrementer write with bit 31 set raises `dec_irq` in the next cycle only if the decrementer's bit 31 was clear before the write. Any other write does not raise it.
- R6: Writing 0 to the decrementer raises no interrupt at once. The first tick after the write expires it.
- R7: A change of `rate_code` from its value in the previous cycle loads the decrementer with 0xFFFFFFFF and raises no interrupt, even if a tick arrives in the same cycle. A decrementer write in the same cycle takes precedence over the reload.
- R8: `dec_irq` stays high until a cycle with `dec_ack` high. If a new interrupt event happens in the same cycle as the acknowledge, `dec_irq` stays high.
- R9: A write in the same cycle as a tick stores the written value, and that counter does not advance in that cycle.
- R10: With `RTC_MODE` = 1, the lower time-base word is masked with 0x3FFFFF80 on write and on read. The counter still advances by one per tick underneath the mask.
- R11: Select code 3 reads 0, and a write with select code 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle count enable |
| rate_code | input | RATE_W | Tick-rate setting; any change reloads the decrementer |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target select |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read source select |
| rd_data | output | 32 | Combinational read data |
| dec_ack | input | 1 | Clears the pending decrementer interrupt |
| dec_irq | output | 1 | Decrementer interrupt request |

## Verification
The bench builds two copies that share all stimulus: `u0` with `RTC_MODE` = 0 and `u1` with `RTC_MODE` = 1. Comparing the two lower words after the same writes and ticks shows the read and write masks. It also shows that a carry into the upper word happens in the plain copy and not in the masked one. `RATE_W` stays at 4, which leaves enough distinct rate codes for three separate reload events.

// File: rtl/tbd_pkg.sv
package tbd_pkg;

    localparam int unsigned WORD_W = 32;
    localparam logic [WORD_W-1:0] RTC_LO_MASK = 32'h3FFF_FF80;

    typedef enum logic [1:0] {
        SEL_TB_LO = 2'd0,
        SEL_TB_HI = 2'd1,
        SEL_DEC   = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              en;
        reg_sel_e          sel;
        logic [WORD_W-1:0] data;
    } wr_req_t;

    function automatic logic [WORD_W-1:0] lo_view(input logic rtc, input logic [WORD_W-1:0] v);
        return rtc ? (v & RTC_LO_MASK) : v;
    endfunction

    function automatic logic is_neg(input logic [WORD_W-1:0] v);
        return v[WORD_W-1];
    endfunction

endpackage

// File: rtl/tbd_timebase.sv
module tbd_timebase
    import tbd_pkg::*;
#(
    parameter bit RTC_MODE = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick_en,
    input  wr_req_t               wr,
    output logic [2*WORD_W-1:0]   tb_q
);
    localparam int unsigned TB_W = 2 * WORD_W;

    logic              wr_lo;
    logic              wr_hi;
    logic [WORD_W-1:0] lo_wdata;
    logic [TB_W-1:0]   tb_d;

    assign wr_lo = wr.en && (wr.sel == SEL_TB_LO);
    assign wr_hi = wr.en && (wr.sel == SEL_TB_HI);

    generate
        if (RTC_MODE) begin : g_rtc
            assign lo_wdata = wr.data & RTC_LO_MASK;
        end else begin : g_plain
            assign lo_wdata = wr.data;
        end
    endgenerate

    always_comb begin
        tb_d = tb_q;
        if (wr_lo) begin
            tb_d[WORD_W-1:0] = lo_wdata;
        end else if (wr_hi) begin
            tb_d[TB_W-1:WORD_W] = wr.data;
        end else if (tick_en) begin
            tb_d = tb_q + TB_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tb_q <= '0;
        end else begin
            tb_q <= tb_d;
        end
    end

    // R2
    tb_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !wr_lo && !wr_hi) |=> (tb_q == $past(tb_q) + TB_W'(1)));

    // R2
    tb_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !wr_lo && !wr_hi) |=> $stable(tb_q));

    // R3
    hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> (tb_q[WORD_W-1:0] == $past(tb_q[WORD_W-1:0])));

    // R3
    lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> (tb_q[TB_W-1:WORD_W] == $past(tb_q[TB_W-1:WORD_W])));

    // R9
    hi_wr_beats_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_hi && tick_en) |=> (tb_q[TB_W-1:WORD_W] == $past(wr.data)));

endmodule

// File: rtl/tbd_decr.sv
module tbd_decr
    import tbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              reload,
    input  wr_req_t           wr,
    output logic [WORD_W-1:0] dec_q,
    output logic              irq_evt
);
    logic              wr_dec;
    logic              neg_cross;
    logic              expire;
    logic [WORD_W-1:0] dec_d;

    assign wr_dec    = wr.en && (wr.sel == SEL_DEC);
    assign neg_cross = wr_dec && is_neg(wr.data) && !is_neg(dec_q);
    assign expire    = !wr_dec && !reload && tick_en && (dec_q == '0);
    assign irq_evt   = neg_cross || expire;

    always_comb begin
        dec_d = dec_q;
        if (wr_dec) begin
            dec_d = wr.data;
        end else if (reload) begin
            dec_d = '1;
        end else if (tick_en) begin
            dec_d = dec_q - WORD_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '1;
        end else begin
            dec_q <= dec_d;
        end
    end

    // R4
    dec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !wr_dec && !reload && (dec_q != '0)) |=> (dec_q == $past(dec_q) - WORD_W'(1)));

    // R4
    dec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !wr_dec && !reload && (dec_q == '0)) |=> (dec_q == '1));

    // R7
    dec_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (reload && !wr_dec) |=> (dec_q == '1));

    // R9
    dec_wr_beats_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_dec && tick_en) |=> (dec_q == $past(wr.data)));

endmodule

// File: rtl/tbd_irq_hold.sv
module tbd_irq_hold (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic ack,
    output logic irq_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else if (set) begin
            irq_q <= 1'b1;
        end else if (ack) begin
            irq_q <= 1'b0;
        end
    end

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !ack) |=> irq_q);

    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !set) |=> !irq_q);

    // R8
    irq_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set |=> irq_q);

endmodule

// File: rtl/tbd_top.sv
module tbd_top
    import tbd_pkg::*;
#(
    parameter bit          RTC_MODE = 1'b0,
    parameter int unsigned RATE_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [RATE_W-1:0] rate_code,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic [1:0]        rd_sel,
    output logic [31:0]       rd_data,
    input  logic              dec_ack,
    output logic              dec_irq
);
    localparam int unsigned TB_W = 2 * WORD_W;

    wr_req_t           wr;
    logic [TB_W-1:0]   tb_val;
    logic [WORD_W-1:0] dec_val;
    logic [RATE_W-1:0] rate_q;
    logic              reload;
    logic              irq_evt;

    assign wr.en   = wr_en;
    assign wr.sel  = reg_sel_e'(wr_sel);
    assign wr.data = wr_data;

    always_ff @(posedge clk) begin
        rate_q <= rate_code;
    end

    assign reload = !rst && (rate_code != rate_q);

    tbd_timebase #(.RTC_MODE(RTC_MODE)) u_tb (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .wr      (wr),
        .tb_q    (tb_val)
    );

    tbd_decr u_dec (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .reload  (reload),
        .wr      (wr),
        .dec_q   (dec_val),
        .irq_evt (irq_evt)
    );

    tbd_irq_hold u_irq (
        .clk   (clk),
        .rst   (rst),
        .set   (irq_evt),
        .ack   (dec_ack),
        .irq_q (dec_irq)
    );

    always_comb begin
        case (reg_sel_e'(rd_sel))
            SEL_TB_LO: rd_data = lo_view(RTC_MODE, tb_val[WORD_W-1:0]);
            SEL_TB_HI: rd_data = tb_val[TB_W-1:WORD_W];
            SEL_DEC:   rd_data = dec_val;
            default:   rd_data = '0;
        endcase
    end

    // R5
    neg_write_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_sel == 2'd2) && wr_data[31] && !dec_val[31]) |=> dec_irq);

    // R5
    neg_over_neg_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_sel == 2'd2) && dec_val[31] && !dec_irq) |=> !dec_irq);

    // R7
    reload_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (reload && !(wr_en && (wr_sel == 2'd2)) && !dec_irq) |=> !dec_irq);

    // R4
    expire_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !wr_en && !reload && (dec_val == '0)) |=> dec_irq);

    // R11
    null_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_sel == 2'd3) && !tick_en && !reload) |=> ($stable(tb_val) && $stable(dec_val)));

endmodule

// File: tb/sim_tbd_top.sv
`timescale 1ns/1ps
module sim_tbd_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic [3:0]  rate_code = 4'd0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic        dec_ack = 1'b0;
    logic [31:0] rd0, rd1;
    logic        irq0, irq1;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    tbd_top #(.RTC_MODE(1'b0), .RATE_W(4)) u0 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .rate_code(rate_code),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd0), .dec_ack(dec_ack), .dec_irq(irq0));

    tbd_top #(.RTC_MODE(1'b1), .RATE_W(4)) u1 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .rate_code(rate_code),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd1), .dec_ack(dec_ack), .dec_irq(irq1));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // one active cycle, then inputs return to idle; checks follow on the negedge
    task automatic cyc(input logic t, input logic w, input logic [1:0] s,
                       input logic [31:0] d, input logic a, input logic [3:0] r);
        @(negedge clk);
        tick_en = t; wr_en = w; wr_sel = s; wr_data = d; dec_ack = a; rate_code = r;
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0; dec_ack = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] v0, output logic [31:0] v1);
        rd_sel = s;
        #0.5;
        v0 = rd0;
        v1 = rd1;
    endtask

    task automatic t_reset;
        logic [31:0] a, b;
        rd(2'd0, a, b); chk("R1 lo u0", a, 32'h0); chk("R1 lo u1", b, 32'h0);
        rd(2'd1, a, b); chk("R1 hi u0", a, 32'h0);
        rd(2'd2, a, b); chk("R1 dec", a, 32'hFFFF_FFFF);
        chk("R1 irq", {31'b0, irq0}, 32'h0);
    endtask

    task automatic t_count;
        logic [31:0] a, b;
        repeat (3) cyc(0, 0, 0, 0, 0, 0);
        rd(2'd0, a, b); chk("R2 idle lo", a, 32'h0);
        repeat (5) cyc(1, 0, 0, 0, 0, 0);
        rd(2'd0, a, b); chk("R2 lo after 5", a, 32'h5); chk("R10 lo u1 masked", b, 32'h0);
        rd(2'd2, a, b); chk("R4 dec after 5", a, 32'hFFFF_FFFA);
        chk("R4 no irq", {31'b0, irq0}, 32'h0);
    endtask

    task automatic t_words;
        logic [31:0] a, b;
        cyc(0, 1, 2'd0, 32'hFFFF_FFFE, 0, 0);
        rd(2'd0, a, b); chk("R3 lo write", a, 32'hFFFF_FFFE); chk("R10 lo write u1", b, 32'h3FFF_FF80);
        repeat (2) cyc(1, 0, 0, 0, 0, 0);
        rd(2'd0, a, b); chk("R2 lo wrap", a, 32'h0); chk("R10 u1 hidden bits", b, 32'h3FFF_FF80);
        rd(2'd1, a, b); chk("R2 carry u0", a, 32'h1); chk("R10 no carry u1", b, 32'h0);
        cyc(0, 1, 2'd1, 32'h1234_5678, 0, 0);
        rd(2'd1, a, b); chk("R3 hi write", a, 32'h1234_5678); chk("R3 hi write u1", b, 32'h1234_5678);
        rd(2'd0, a, b); chk("R3 lo kept", a, 32'h0); chk("R3 lo kept u1", b, 32'h3FFF_FF80);
        cyc(1, 1, 2'd0, 32'h0000_0100, 0, 0);
        rd(2'd0, a, b); chk("R9 lo write vs tick", a, 32'h100); chk("R9 u1", b, 32'h100);
        rd(2'd1, a, b); chk("R3 hi kept", a, 32'h1234_5678);
        rd(2'd2, a, b); chk("R4 dec", a, 32'hFFFF_FFF7);
    endtask

    task automatic t_null_sel;
        logic [31:0] a, b;
        cyc(0, 1, 2'd3, 32'hDEAD_BEEF, 0, 0);
        rd(2'd3, a, b); chk("R11 sel3 reads 0", a, 32'h0);
        rd(2'd0, a, b); chk("R11 lo intact", a, 32'h100);
        rd(2'd1, a, b); chk("R11 hi intact", a, 32'h1234_5678);
        rd(2'd2, a, b); chk("R11 dec intact", a, 32'hFFFF_FFF7);
    endtask

    task automatic t_expire;
        logic [31:0] a, b;
        cyc(0, 1, 2'd2, 32'h3, 0, 0);
        rd(2'd2, a, b); chk("R5 pos write dec", a, 32'h3);
        chk("R5 pos write no irq", {31'b0, irq0}, 32'h0);
        repeat (3) cyc(1, 0, 0, 0, 0, 0);
        rd(2'd2, a, b); chk("R4 at zero", a, 32'h0);
        chk("R4 no irq at zero", {31'b0, irq0}, 32'h0);
        cyc(1, 0, 0, 0, 0, 0);
        rd(2'd2, a, b); chk("R4 wrap value", a, 32'hFFFF_FFFF);
        chk("R4 irq on expire", {31'b0, irq0}, 32'h1);
        cyc(1, 0, 0, 0, 0, 0);
        chk("R8 irq held", {31'b0, irq0}, 32'h1);
        rd(2'd2, a, b); chk("R4 keeps counting", a, 32'hFFFF_FFFE);
        cyc(0, 0, 0, 0, 1, 0);
        chk("R8 ack clears", {31'b0, irq0}, 32'h0);
    endtask

    task automatic t_zero_write;
        logic [31:0] a, b;
        cyc(0, 1, 2'd2, 32'h0, 0, 0);
        chk("R6 zero write no irq", {31'b0, irq0}, 32'h0);
        cyc(1, 0, 0, 0, 0, 0);
        chk("R6 expires next tick", {31'b0, irq0}, 32'h1);
        rd(2'd2, a, b); chk("R6 dec wrapped", a, 32'hFFFF_FFFF);
        cyc(0, 0, 0, 0, 1, 0);
        chk("R8 ack", {31'b0, irq0}, 32'h0);
    endtask

    task automatic t_neg_write;
        logic [31:0] a, b;
        cyc(0, 1, 2'd2, 32'h10, 0, 0);
        chk("R5 pos write quiet", {31'b0, irq0}, 32'h0);
        cyc(0, 1, 2'd2, 32'h8000_0000, 0, 0);
        chk("R5 neg over pos fires", {31'b0, irq0}, 32'h1);
        rd(2'd2, a, b); chk("R5 value stored", a, 32'h8000_0000);
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 1, 2'd2, 32'h9000_0000, 0, 0);
        chk("R5 neg over neg quiet", {31'b0, irq0}, 32'h0);
        cyc(1, 1, 2'd2, 32'h7, 0, 0);
        rd(2'd2, a, b); chk("R9 dec write vs tick", a, 32'h7);
    endtask

    task automatic t_rate;
        logic [31:0] a, b;
        cyc(0, 1, 2'd2, 32'h5, 0, 0);
        cyc(0, 0, 0, 0, 0, 4'd1);
        rd(2'd2, a, b); chk("R7 reload value", a, 32'hFFFF_FFFF);
        chk("R7 reload quiet", {31'b0, irq0}, 32'h0);
        cyc(0, 1, 2'd2, 32'h0, 0, 4'd1);
        cyc(1, 0, 0, 0, 0, 4'd2);
        rd(2'd2, a, b); chk("R7 reload beats tick", a, 32'hFFFF_FFFF);
        chk("R7 no expire on reload", {31'b0, irq0}, 32'h0);
        cyc(0, 1, 2'd2, 32'h20, 0, 4'd3);
        rd(2'd2, a, b); chk("R7 write beats reload", a, 32'h20);
    endtask

    task automatic t_ack_race;
        logic [31:0] a, b;
        cyc(0, 1, 2'd2, 32'h0, 0, 4'd3);
        cyc(1, 0, 0, 0, 0, 4'd3);
        chk("R8 armed", {31'b0, irq0}, 32'h1);
        cyc(0, 1, 2'd2, 32'h1, 0, 4'd3);
        cyc(1, 0, 0, 0, 0, 4'd3);
        chk("R8 still held", {31'b0, irq0}, 32'h1);
        cyc(1, 0, 0, 0, 1, 4'd3);
        chk("R8 set beats ack", {31'b0, irq0}, 32'h1);
        rd(2'd2, a, b); chk("R4 wrap in race", a, 32'hFFFF_FFFF);
        cyc(0, 0, 0, 0, 1, 4'd3);
        chk("R8 final ack", {31'b0, irq0}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_count();
        t_words();
        t_null_sel();
        t_expire();
        t_zero_write();
        t_neg_write();
        t_rate();
        t_ack_race();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule